// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides which NaN a fused multiply-add `(A*B)+C` returns when at least one operand is a NaN, or when the multiplicands are infinity times zero. It receives three operand class codes and an infinity-times-zero indicator. It returns a two-bit choice: operand A, operand B, operand C, or the default NaN. It also reports an invalid-operation flag and an infinity-times-zero sub-flag. The datapath that builds the NaN value and the arithmetic itself live elsewhere.

Several architectural conventions disagree on two points: the priority among the operands, and what happens in the infinity-times-zero case. A runtime mode input selects the convention, and a use-first input refines one of them. The result is registered: one cycle after a valid request the answer appears with `res_valid`.

Top module: `fma_nan_sel`

## Requirements
- R1: Class codes are 2'b00 not a NaN, 2'b01 quiet NaN, 2'b10 signaling NaN, and 2'b11 is treated as not a NaN. The choice code is 0 = A, 1 = B, 2 = C, 3 = default NaN. A request accepted with `req_valid` high at a rising edge appears on `res_choice`, `res_invalid` and `res_imz` with `res_valid` high after that same edge.
- R2: After reset `res_valid`, `res_invalid` and `res_imz` are 0. After any edge with `req_valid` low, both flags and `res_valid` are 0.
- R3: Mode 1 (C first, default on quiet C): if infinity-times-zero is set and C is a quiet NaN, the block raises invalid and chooses the default NaN. Otherwise it chooses the first match of signaling C, signaling A, signaling B, NaN C, NaN A, and else B.
- R4: Mode 2 (legacy polarity): infinity-times-zero raises invalid and chooses the default NaN. Otherwise it chooses the first match of signaling A, B, C, then NaN A, NaN B, and else C.
- R5: Mode 3 (newer standard): infinity-times-zero raises invalid and chooses C. Otherwise the order is the same as in R3.
- R6: Mode 4 (first NaN): infinity-times-zero raises invalid and chooses C. Otherwise it chooses A if A is a NaN, else C if C is a NaN, else B.
- R7: Mode 5 (always default): the choice is always the default NaN, and infinity-times-zero raises invalid.
- R8: Mode 6 (switchable): infinity-times-zero raises invalid and chooses C. Otherwise, with `req_use_first` = 1 the order is A, B, else C by any NaN; with `req_use_first` = 0 the order is C, B, else A.
- R9: Modes 0 and 7 (fallback) choose A if A is a NaN, else B if B is a NaN, else C, and never raise invalid.
- R10: `res_imz` is 1 exactly when `res_invalid` is 1, since infinity-times-zero is the only source of invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Convention select (codes in R3 to R9) |
| req_use_first | input | 1 | Order refinement for mode 6 |
| req_a_cls | input | 2 | Class of operand A |
| req_b_cls | input | 2 | Class of operand B |
| req_c_cls | input | 2 | Class of operand C |
| req_inf_zero | input | 1 | Multiplicands are infinity and zero |
| res_valid | output | 1 | Result present |
| res_choice | output | 2 | 0 A, 1 B, 2 C, 3 default NaN |
| res_invalid | output | 1 | Invalid-operation flag |
| res_imz | output | 1 | Infinity-times-zero sub-flag |

## Verification
The assertions check on every cycle that the flags and `res_valid` follow the request one edge later and drop without one. They also check that the sub-flag always pairs with invalid, that the always-default and fallback modes keep their choice or flag promises, and that the modes which send infinity-times-zero to C do so. The orderings within each mode only show in the bench's scenarios. These include a signaling operand outranking an earlier quiet one, the quiet-C exception of mode 1, the use-first switch, and the treatment of class 2'b11.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
  localparam int CLS_W   = 2;
  localparam int SEL_W   = 2;
  localparam int NUM_OPS = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int MODE_W  = 3;

  typedef logic [CLS_W-1:0] cls_t;
  typedef logic [SEL_W-1:0] choice_t;

  localparam cls_t CLS_NONE = 2'b00;
  localparam cls_t CLS_QNAN = 2'b01;
  localparam cls_t CLS_SNAN = 2'b10;

  localparam choice_t PICK_A    = 2'd0;
  localparam choice_t PICK_B    = 2'd1;
  localparam choice_t PICK_C    = 2'd2;
  localparam choice_t PICK_DFLT = 2'd3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FALLBACK   = 3'd0,
    MODE_CFIRST_DFQ = 3'd1,
    MODE_LEGACY     = 3'd2,
    MODE_NEWSTD     = 3'd3,
    MODE_FIRSTNAN   = 3'd4,
    MODE_ALWAYSDEF  = 3'd5,
    MODE_SWITCH     = 3'd6,
    MODE_FALLBACK2  = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    IMZ_IGNORE,
    IMZ_DEFAULT,
    IMZ_DEFAULT_IF_CQ,
    IMZ_TAKE_C,
    IMZ_FLAG_ONLY
  } imz_act_e;

  function automatic logic is_nan(input cls_t c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction
endpackage

// File: rtl/fma_nan_policy.sv
module fma_nan_policy
  import fma_nan_pkg::*;
(
  input  logic [MODE_W-1:0]            mode,
  input  logic                         use_first,
  output logic [NUM_OPS-1:0][SEL_W-1:0] order,
  output logic                         snan_first,
  output imz_act_e                     imz_act,
  output logic                         force_dflt
);
  always_comb begin
    order      = {PICK_C, PICK_B, PICK_A};
    snan_first = 1'b0;
    imz_act    = IMZ_IGNORE;
    force_dflt = 1'b0;
    case (mode_e'(mode))
      MODE_CFIRST_DFQ: begin
        order      = {PICK_B, PICK_A, PICK_C};
        snan_first = 1'b1;
        imz_act    = IMZ_DEFAULT_IF_CQ;
      end
      MODE_LEGACY: begin
        snan_first = 1'b1;
        imz_act    = IMZ_DEFAULT;
      end
      MODE_NEWSTD: begin
        order      = {PICK_B, PICK_A, PICK_C};
        snan_first = 1'b1;
        imz_act    = IMZ_TAKE_C;
      end
      MODE_FIRSTNAN: begin
        order   = {PICK_B, PICK_C, PICK_A};
        imz_act = IMZ_TAKE_C;
      end
      MODE_ALWAYSDEF: begin
        imz_act    = IMZ_FLAG_ONLY;
        force_dflt = 1'b1;
      end
      MODE_SWITCH: begin
        order   = use_first ? {PICK_C, PICK_B, PICK_A} : {PICK_A, PICK_B, PICK_C};
        imz_act = IMZ_TAKE_C;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
  import fma_nan_pkg::*;
(
  input  logic [NUM_OPS-1:0][CLS_W-1:0] cls_in,
  input  logic [NUM_OPS-1:0][SEL_W-1:0] order,
  input  logic                          snan_first,
  output logic [SEL_W-1:0]              pick
);
  logic [NUM_SEL-1:0][CLS_W-1:0] cls_pad;
  logic [NUM_OPS-1:0][CLS_W-1:0] ranked;

  generate
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_pad
      if (g < NUM_OPS) begin : g_op
        assign cls_pad[g] = cls_in[g];
      end else begin : g_none
        assign cls_pad[g] = CLS_NONE;
      end
    end
    for (genvar r = 0; r < NUM_OPS; r++) begin : g_rank
      assign ranked[r] = cls_pad[order[r]];
    end
  endgenerate

  always_comb begin
    logic found;
    pick  = order[NUM_OPS-1];
    found = 1'b0;
    if (snan_first) begin
      for (int i = 0; i < NUM_OPS; i++) begin
        if (!found && ranked[i] == CLS_SNAN) begin
          pick  = order[i];
          found = 1'b1;
        end
      end
    end
    for (int i = 0; i < NUM_OPS; i++) begin
      if (!found && is_nan(ranked[i])) begin
        pick  = order[i];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fma_nan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_use_first,
  input  logic [CLS_W-1:0]  req_a_cls,
  input  logic [CLS_W-1:0]  req_b_cls,
  input  logic [CLS_W-1:0]  req_c_cls,
  input  logic              req_inf_zero,
  output logic              res_valid,
  output logic [SEL_W-1:0]  res_choice,
  output logic              res_invalid,
  output logic              res_imz
);
  logic [NUM_OPS-1:0][SEL_W-1:0] order;
  logic                          snan_first;
  imz_act_e                      imz_act;
  logic                          force_dflt;
  logic [SEL_W-1:0]              pick;

  logic             imz_hit;
  logic [SEL_W-1:0] choice_d;
  logic             inv_d;
  logic             valid_d;

  fma_nan_policy u_policy (
    .mode       (req_mode),
    .use_first  (req_use_first),
    .order      (order),
    .snan_first (snan_first),
    .imz_act    (imz_act),
    .force_dflt (force_dflt)
  );

  fma_nan_pick u_pick (
    .cls_in     ({req_c_cls, req_b_cls, req_a_cls}),
    .order      (order),
    .snan_first (snan_first),
    .pick       (pick)
  );

  always_comb begin
    case (imz_act)
      IMZ_DEFAULT, IMZ_TAKE_C, IMZ_FLAG_ONLY: imz_hit = req_inf_zero;
      IMZ_DEFAULT_IF_CQ: imz_hit = req_inf_zero && (req_c_cls == CLS_QNAN);
      default:           imz_hit = 1'b0;
    endcase

    if (force_dflt)                              choice_d = PICK_DFLT;
    else if (imz_hit && imz_act == IMZ_TAKE_C)   choice_d = PICK_C;
    else if (imz_hit)                            choice_d = PICK_DFLT;
    else                                         choice_d = pick;

    valid_d = req_valid;
    inv_d   = req_valid && imz_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_invalid <= 1'b0;
      res_imz     <= 1'b0;
      res_choice  <= PICK_A;
    end else begin
      res_valid   <= valid_d;
      res_invalid <= inv_d;
      res_imz     <= inv_d;
      if (req_valid) res_choice <= choice_d;
    end
  end

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_invalid && !res_imz));
  assert_newstd_imz_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inf_zero && req_mode == MODE_NEWSTD) |=> (res_choice == PICK_C && res_invalid));
  assert_firstnan_imz_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inf_zero && req_mode == MODE_FIRSTNAN) |=> (res_choice == PICK_C && res_invalid));
  assert_always_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MODE_ALWAYSDEF) |=> res_choice == PICK_DFLT);
  assert_switch_imz_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inf_zero && req_mode == MODE_SWITCH) |=> (res_choice == PICK_C && res_invalid));
  assert_fallback_no_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == MODE_FALLBACK || req_mode == MODE_FALLBACK2)) |=> !res_invalid);
  assert_subflag_pairs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_imz == res_invalid);
endmodule

// File: tb/fma_nan_sel_tb.sv
module fma_nan_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic       req_use_first = 1'b0;
  logic [1:0] req_a_cls = '0, req_b_cls = '0, req_c_cls = '0;
  logic       req_inf_zero = 1'b0;
  logic       res_valid;
  logic [1:0] res_choice;
  logic       res_invalid, res_imz;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] N = 2'b00, Q = 2'b01, S = 2'b10, X = 2'b11;

  always #4 clk = ~clk;

  fma_nan_sel dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_use_first(req_use_first), .req_a_cls(req_a_cls), .req_b_cls(req_b_cls),
    .req_c_cls(req_c_cls), .req_inf_zero(req_inf_zero), .res_valid(res_valid),
    .res_choice(res_choice), .res_invalid(res_invalid), .res_imz(res_imz)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge, sample after the next rising edge.
  task automatic run(input string tag, input logic [2:0] m, input logic uf,
                     input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                     input logic iz, input int exp_sel, input int exp_inv);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_use_first = uf;
    req_a_cls = a; req_b_cls = b; req_c_cls = c; req_inf_zero = iz;
    @(negedge clk);
    req_valid = 1'b0; req_inf_zero = 1'b0;
    check({tag, " valid R1"}, res_valid, 1);
    check({tag, " choice"}, res_choice, exp_sel);
    check({tag, " invalid"}, res_invalid, exp_inv);
    check({tag, " imz R10"}, res_imz, exp_inv);
  endtask

  task automatic t_reset_R2();
    check("R2 reset valid", res_valid, 0);
    check("R2 reset invalid", res_invalid, 0);
    check("R2 reset imz", res_imz, 0);
  endtask

  task automatic t_idle_R2();
    run("R2 pre", 3'd2, 0, N, N, N, 1, 3, 1);
    @(negedge clk);
    check("R2 idle valid", res_valid, 0);
    check("R2 idle invalid", res_invalid, 0);
    check("R2 idle imz", res_imz, 0);
  endtask

  task automatic t_cfirst_R3();
    run("R3 iz cq",  3'd1, 0, N, N, Q, 1, 3, 1);
    run("R3 iz cs",  3'd1, 0, Q, N, S, 1, 2, 0);
    run("R3 sa>qc",  3'd1, 0, S, N, Q, 0, 0, 0);
    run("R3 qa qc",  3'd1, 0, Q, N, Q, 0, 2, 0);
    run("R3 sb>qa",  3'd1, 0, Q, S, N, 0, 1, 0);
    run("R3 qb",     3'd1, 0, N, Q, N, 0, 1, 0);
  endtask

  task automatic t_legacy_R4();
    run("R4 iz",     3'd2, 0, N, N, Q, 1, 3, 1);
    run("R4 sc>qa",  3'd2, 0, Q, N, S, 0, 2, 0);
    run("R4 sa sb",  3'd2, 0, S, S, N, 0, 0, 0);
    run("R4 qb qc",  3'd2, 0, N, Q, Q, 0, 1, 0);
    run("R4 qc",     3'd2, 0, N, N, Q, 0, 2, 0);
  endtask

  task automatic t_newstd_R5();
    run("R5 iz",     3'd3, 0, Q, N, N, 1, 2, 1);
    run("R5 sa>qc",  3'd3, 0, S, N, Q, 0, 0, 0);
    run("R5 sc>sa",  3'd3, 0, S, N, S, 0, 2, 0);
    run("R5 sb>qc",  3'd3, 0, N, S, Q, 0, 1, 0);
    run("R5 qa qb",  3'd3, 0, Q, Q, N, 0, 0, 0);
  endtask

  task automatic t_firstnan_R6();
    run("R6 iz",     3'd4, 0, N, Q, N, 1, 2, 1);
    run("R6 qa sc",  3'd4, 0, Q, N, S, 0, 0, 0);
    run("R6 sb qc",  3'd4, 0, N, S, Q, 0, 2, 0);
    run("R6 qb",     3'd4, 0, N, Q, N, 0, 1, 0);
  endtask

  task automatic t_alwaysdef_R7();
    run("R7 qa",     3'd5, 0, Q, N, N, 0, 3, 0);
    run("R7 iz",     3'd5, 0, N, N, S, 1, 3, 1);
  endtask

  task automatic t_switch_R8();
    run("R8 uf1 qb sc", 3'd6, 1, N, Q, S, 0, 1, 0);
    run("R8 uf1 qa sc", 3'd6, 1, Q, N, S, 0, 0, 0);
    run("R8 uf1 c",     3'd6, 1, N, N, Q, 0, 2, 0);
    run("R8 uf0 sa qb", 3'd6, 0, S, Q, N, 0, 1, 0);
    run("R8 uf0 sa qc", 3'd6, 0, S, N, Q, 0, 2, 0);
    run("R8 uf0 a",     3'd6, 0, Q, N, N, 0, 0, 0);
    run("R8 iz",        3'd6, 1, Q, N, N, 1, 2, 1);
  endtask

  task automatic t_fallback_R9();
    run("R9 qb sc",  3'd0, 0, N, Q, S, 0, 1, 0);
    run("R9 c",      3'd0, 0, N, N, Q, 0, 2, 0);
    run("R9 sa",     3'd0, 0, S, Q, Q, 0, 0, 0);
    run("R9 iz",     3'd0, 0, N, N, Q, 1, 2, 0);
    run("R9 m7 sa",  3'd7, 0, S, N, Q, 1, 0, 0);
    run("R9 R1 x11", 3'd0, 0, X, Q, N, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R2();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R2();
    t_cfirst_R3();
    t_legacy_R4();
    t_newstd_R5();
    t_firstnan_R6();
    t_alwaysdef_R7();
    t_switch_R8();
    t_fallback_R9();
    t_idle_R2();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule